// File: doc/BRIEF.md
# Device Identification Responder

This block is the slave-side sequencer that answers the reserved identification query on a two-wire serial bus. A bit-level shifter elsewhere decodes the wires into single-cycle events: a START (plain or repeated), a STOP, a complete received byte, and the master's acknowledge slot after a byte the slave sent. The responder follows these events through a three-step enable sequence. It tells the shifter when to acknowledge a received byte, and it supplies the byte to shift out while it is the transmitter.

The query runs as follows. After a START the master sends the reserved identification address with the write bit (0xF8). It then sends the target slave address; bit 0 of that byte is ignored. A repeated START follows, then the reserved address with the read bit (0xF9). The responder then returns a 24-bit identity, one byte per master acknowledge. The identity packs a 12-bit manufacturer field, a 9-bit part field and a 3-bit revision field, all set by module parameters. A STOP, a foreign address or an out-of-order byte drops the sequence. A master NACK ends the read.

Top module: `devid_responder`

## Requirements
- R1: After reset, ack_en and tx_en are 0 and tx_byte is 0x00.
- R2: A byte received as the first byte after a START from the idle state is acknowledged only if it equals 0xF8. Every other value leaves ack_en at 0, and the sequence returns to idle.
- R3: The byte that follows an acknowledged 0xF8 is acknowledged when its bits [7:1] equal own_addr, whatever bit 0 holds. On a mismatch it is not acknowledged, and a later START with 0xF9 gets no acknowledge.
- R4: After a matched own address, a repeated START followed by 0xF9 is acknowledged. In the same cycle that ack_en rises, tx_en rises and tx_byte presents identity byte 0.
- R5: The identity is the concatenation {MFR_ID[11:0], PART_ID[8:0], REV_ID[2:0]}. Byte 0 is bits [23:16], byte 1 is bits [15:8] and byte 2 is bits [7:0].
- R6: Each master acknowledge (ev_mack with mack_nack=0) while transmitting moves tx_byte to the next byte, and byte 2 wraps to byte 0. tx_byte holds steady between master acknowledge slots.
- R7: A master NACK (ev_mack with mack_nack=1) while transmitting clears tx_en and tx_byte in the next cycle. A later full query starts again at byte 0.
- R8: A STOP at any step, including during transmission, returns the block to idle: ack_en and tx_en are 0 in the next cycle, and a later START with 0xF9 gets no acknowledge.
- R9: A repeated START followed by any byte other than 0xF9 after a matched own address cancels the query. A further repeated START with 0xF9 gets no acknowledge.
- R10: 0xF9 sent without the preceding steps is not acknowledged. A received byte that arrives where a repeated START was expected cancels the query.
- R11: ack_en rises only in the cycle after a received-byte event. It stays high until the next event of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 7 | Configured 7-bit slave address |
| ev_start | input | 1 | One-cycle pulse: START or repeated START seen |
| ev_stop | input | 1 | One-cycle pulse: STOP seen |
| ev_byte | input | 1 | One-cycle pulse: a full byte received into rx_byte |
| rx_byte | input | 8 | Received byte, valid with ev_byte |
| ev_mack | input | 1 | One-cycle pulse: master acknowledge slot after a sent byte |
| mack_nack | input | 1 | Level of that slot: 1 = NACK, 0 = ACK |
| ack_en | output | 1 | Drive ACK for the byte just received |
| tx_en | output | 1 | Responder is transmitting identity bytes |
| tx_byte | output | 8 | Byte to shift out next, 0x00 when not transmitting |

## Verification
A wrong sequence state appears at ack_en one cycle after the byte that exposes it. A step that was wrongly kept alive acknowledges a reserved address it should refuse. A step that was wrongly dropped withholds an expected acknowledge. A wrong byte pointer appears at tx_byte in the cycle that tx_en rises, or one cycle after a master acknowledge. The bench therefore sweeps all 256 values of the first byte and of the address byte. It then walks several wrapping reads and cancellation paths, and checks each output in the cycle right after the event that moves it.

// File: rtl/devid_pkg.sv
package devid_pkg;

    localparam int MFR_W   = 12;
    localparam int PART_W  = 9;
    localparam int REV_W   = 3;
    localparam int ID_W    = MFR_W + PART_W + REV_W;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = ID_W / BYTE_W;
    localparam int PTR_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int ADDR_W  = 7;

    localparam logic [BYTE_W-1:0] RSV_ID_WR = 8'hF8;
    localparam logic [BYTE_W-1:0] RSV_ID_RD = 8'hF9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXP_RW,
        ST_EXP_OWN,
        ST_EXP_SR,
        ST_EXP_RR,
        ST_SEND
    } seq_state_t;

    typedef struct packed {
        logic              start;
        logic              stop;
        logic              byte_v;
        logic [BYTE_W-1:0] data;
        logic              mack_v;
        logic              mack_nack;
    } bus_ev_t;

    function automatic logic [ID_W-1:0] pack_id(
        input logic [MFR_W-1:0]  mfr,
        input logic [PART_W-1:0] part,
        input logic [REV_W-1:0]  rev
    );
        return {mfr, part, rev};
    endfunction

endpackage

// File: rtl/devid_seq.sv
module devid_seq
    import devid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] own_addr,
    input  bus_ev_t           ev,
    output logic              ack_q,
    output logic              send_q,
    output logic              send_nxt,
    output logic              adv
);

    seq_state_t st_q, st_d;
    logic       ack_d;

    always_comb begin
        st_d  = st_q;
        ack_d = ack_q;
        adv   = 1'b0;
        if (ev.stop) begin
            st_d  = ST_IDLE;
            ack_d = 1'b0;
        end else if (ev.start) begin
            ack_d = 1'b0;
            st_d  = (st_q == ST_EXP_SR) ? ST_EXP_RR : ST_EXP_RW;
        end else if (ev.byte_v) begin
            ack_d = 1'b0;
            st_d  = ST_IDLE;
            case (st_q)
                ST_EXP_RW: if (ev.data == RSV_ID_WR) begin
                    st_d  = ST_EXP_OWN;
                    ack_d = 1'b1;
                end
                ST_EXP_OWN: if (ev.data[BYTE_W-1:1] == own_addr) begin
                    st_d  = ST_EXP_SR;
                    ack_d = 1'b1;
                end
                ST_EXP_RR: if (ev.data == RSV_ID_RD) begin
                    st_d  = ST_SEND;
                    ack_d = 1'b1;
                end
                default: st_d = ST_IDLE;
            endcase
        end else if (ev.mack_v) begin
            ack_d = 1'b0;
            if (st_q == ST_SEND) begin
                if (ev.mack_nack) st_d = ST_IDLE;
                else              adv  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ack_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ack_q <= ack_d;
        end
    end

    assign send_q   = (st_q == ST_SEND);
    assign send_nxt = (st_d == ST_SEND);

endmodule

// File: rtl/devid_ptr.sv
module devid_ptr
    import devid_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_zero,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/devid_mux.sv
module devid_mux
    import devid_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_WORD = '0
) (
    input  logic              en,
    input  logic [PTR_W-1:0]  ptr,
    output logic [BYTE_W-1:0] out_byte
);

    logic [BYTE_W-1:0] id_bytes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_slice
        assign id_bytes[g] = ID_WORD[ID_W-1-BYTE_W*g -: BYTE_W];
    end

    always_comb begin
        out_byte = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (en && (ptr == PTR_W'(i))) out_byte = id_bytes[i];
        end
    end

endmodule

// File: rtl/devid_responder.sv
module devid_responder
    import devid_pkg::*;
#(
    parameter logic [MFR_W-1:0]  MFR_ID  = 12'hA5C,
    parameter logic [PART_W-1:0] PART_ID = 9'h13B,
    parameter logic [REV_W-1:0]  REV_ID  = 3'd5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  own_addr,
    input  logic        ev_start,
    input  logic        ev_stop,
    input  logic        ev_byte,
    input  logic [7:0]  rx_byte,
    input  logic        ev_mack,
    input  logic        mack_nack,
    output logic        ack_en,
    output logic        tx_en,
    output logic [7:0]  tx_byte
);

    localparam logic [ID_W-1:0]   ID_WORD    = pack_id(MFR_ID, PART_ID, REV_ID);
    localparam logic [BYTE_W-1:0] FIRST_BYTE = ID_WORD[ID_W-1 -: BYTE_W];

    bus_ev_t          ev;
    logic             send_nxt;
    logic             adv;
    logic [PTR_W-1:0] ptr;

    assign ev = '{start: ev_start, stop: ev_stop, byte_v: ev_byte,
                  data: rx_byte, mack_v: ev_mack, mack_nack: mack_nack};

    devid_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .own_addr (own_addr),
        .ev       (ev),
        .ack_q    (ack_en),
        .send_q   (tx_en),
        .send_nxt (send_nxt),
        .adv      (adv)
    );

    devid_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .hold_zero (!send_nxt),
        .adv       (adv),
        .ptr       (ptr)
    );

    devid_mux #(.ID_WORD(ID_WORD)) u_mux (
        .en       (tx_en),
        .ptr      (ptr),
        .out_byte (tx_byte)
    );

endmodule

// File: rtl/devid_responder_chk.sv
module devid_responder_chk #(
    parameter logic [7:0] FIRST_BYTE = 8'h00
) (
    input logic       clk,
    input logic       rst,
    input logic       ev_start,
    input logic       ev_stop,
    input logic       ev_byte,
    input logic [7:0] rx_byte,
    input logic       ev_mack,
    input logic       mack_nack,
    input logic       ack_en,
    input logic       tx_en,
    input logic [7:0] tx_byte
);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ack_en && !tx_en);

    assert_send_entry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> ack_en && tx_byte == FIRST_BYTE && $past(ev_byte) && $past(rx_byte) == 8'hF9);

    assert_byte_steady_R6: assert property (@(posedge clk) disable iff (rst)
        tx_en && $past(tx_en) && !$past(ev_mack) |-> $stable(tx_byte));

    assert_nack_ends_R7: assert property (@(posedge clk) disable iff (rst)
        tx_en && ev_mack && mack_nack && !ev_start && !ev_stop && !ev_byte
        |=> !tx_en && tx_byte == 8'h00);

    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !tx_en && !ack_en);

    assert_ack_from_byte_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_en) |-> $past(ev_byte));

endmodule

bind devid_responder devid_responder_chk #(.FIRST_BYTE(FIRST_BYTE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ev_byte   (ev_byte),
    .rx_byte   (rx_byte),
    .ev_mack   (ev_mack),
    .mack_nack (mack_nack),
    .ack_en    (ack_en),
    .tx_en     (tx_en),
    .tx_byte   (tx_byte)
);

// File: tb/devid_responder_tb.sv
module devid_responder_tb;

    localparam logic [11:0] T_MFR  = 12'hA5C;
    localparam logic [8:0]  T_PART = 9'h13B;
    localparam logic [2:0]  T_REV  = 3'd5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] own_addr = 7'h2D;
    logic       ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0, ev_mack = 1'b0, mack_nack = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       ack_en, tx_en;
    logic [7:0] tx_byte;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    devid_responder #(.MFR_ID(T_MFR), .PART_ID(T_PART), .REV_ID(T_REV)) u_dut (
        .clk(clk), .rst(rst), .own_addr(own_addr),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte), .rx_byte(rx_byte),
        .ev_mack(ev_mack), .mack_nack(mack_nack),
        .ack_en(ack_en), .tx_en(tx_en), .tx_byte(tx_byte)
    );

    function automatic logic [7:0] exp_byte(input int k);
        logic [23:0] w;
        w = (24'(T_MFR) << 12) | (24'(T_PART) << 3) | 24'(T_REV);
        return 8'((w >> (8 * (2 - (k % 3)))) & 24'hFF);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_start();
        @(negedge clk) ev_start = 1'b1;
        @(negedge clk) ev_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk) ev_stop = 1'b1;
        @(negedge clk) ev_stop = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk) begin ev_byte = 1'b1; rx_byte = b; end
        @(negedge clk) ev_byte = 1'b0;
    endtask

    task automatic do_mack(input logic nack);
        @(negedge clk) begin ev_mack = 1'b1; mack_nack = nack; end
        @(negedge clk) begin ev_mack = 1'b0; mack_nack = 1'b0; end
    endtask

    // full query up to the read address; checks entry into transmit (R4)
    task automatic enter_send(input string tag);
        do_start();
        do_byte(8'hF8);
        do_byte({own_addr, 1'b0});
        do_start();
        do_byte(8'hF9);
        chk(ack_en && tx_en && tx_byte == exp_byte(0), tag, {ack_en, tx_en, tx_byte}, {2'b11, exp_byte(0)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!ack_en && !tx_en && tx_byte == 8'h00, "R1 reset", {ack_en, tx_en, tx_byte}, 0);

        // R2: sweep every first byte after START
        for (int b = 0; b < 256; b++) begin
            do_start();
            do_byte(8'(b));
            chk(ack_en == (b == 8'hF8) && !tx_en, "R2 first byte", ack_en, (b == 8'hF8));
            do_stop();
        end

        // R3/R4/R5/R6/R7: sweep every address byte for two own addresses
        for (int a = 0; a < 2; a++) begin
            own_addr = (a == 0) ? 7'h2D : 7'h52;
            for (int b = 0; b < 256; b++) begin
                bit match;
                match = (b / 2) == int'(own_addr);
                do_start();
                do_byte(8'hF8);
                chk(ack_en == 1'b1, "R2 reserved write", ack_en, 1);
                do_byte(8'(b));
                chk(ack_en == match, "R3 own address", ack_en, match);
                do_start();
                chk(!ack_en, "R11 ack drops on event", ack_en, 0);
                do_byte(8'hF9);
                chk(ack_en == match && tx_en == match, "R3/R4 read address", {ack_en, tx_en}, {match, match});
                if (match) begin
                    chk(tx_byte == exp_byte(0), "R4 R5 byte0", tx_byte, exp_byte(0));
                    repeat (2) @(negedge clk);
                    chk(ack_en && tx_byte == exp_byte(0), "R11 R6 hold", {ack_en, tx_byte}, {1'b1, exp_byte(0)});
                    for (int k = 1; k <= 7; k++) begin
                        do_mack(1'b0);
                        chk(tx_en && tx_byte == exp_byte(k), "R5 R6 next byte", tx_byte, exp_byte(k));
                    end
                    do_mack(1'b1);
                    chk(!tx_en && tx_byte == 8'h00 && !ack_en, "R7 nack ends", {tx_en, tx_byte}, 0);
                end
                do_stop();
            end
        end
        own_addr = 7'h2D;

        // R7: after a NACK mid-cycle, next query restarts at byte 0
        enter_send("R4 entry");
        do_mack(1'b0);
        do_mack(1'b1);
        enter_send("R7 restart at byte0");
        do_mack(1'b1);

        // R8: STOP between steps
        do_start(); do_byte(8'hF8); do_byte({own_addr, 1'b1});
        do_stop();
        chk(!ack_en && !tx_en, "R8 stop clears", {ack_en, tx_en}, 0);
        do_start(); do_byte(8'hF9);
        chk(!ack_en && !tx_en, "R8 no id after stop", {ack_en, tx_en}, 0);
        do_stop();
        // R8: STOP during transmission
        enter_send("R4 entry");
        do_mack(1'b0);
        do_stop();
        chk(!tx_en && tx_byte == 8'h00 && !ack_en, "R8 stop during read", {tx_en, tx_byte}, 0);
        do_start(); do_byte(8'hF9);
        chk(!ack_en, "R8 read addr after stop", ack_en, 0);
        do_stop();

        // R9: repeated START to a foreign device
        do_start(); do_byte(8'hF8); do_byte({own_addr, 1'b0});
        do_start(); do_byte(8'hA4);
        chk(!ack_en && !tx_en, "R9 foreign address", {ack_en, tx_en}, 0);
        do_start(); do_byte(8'hF9);
        chk(!ack_en && !tx_en, "R9 cancelled", {ack_en, tx_en}, 0);
        do_stop();

        // R10: read address out of order, byte where repeated START expected
        do_start(); do_byte(8'hF9);
        chk(!ack_en && !tx_en, "R10 bare read addr", {ack_en, tx_en}, 0);
        do_stop();
        do_start(); do_byte(8'hF8); do_byte({own_addr, 1'b0});
        do_byte(8'h00);
        chk(!ack_en, "R10 data byte instead of Sr", ack_en, 0);
        do_start(); do_byte(8'hF9);
        chk(!ack_en && !tx_en, "R10 cancelled", {ack_en, tx_en}, 0);
        do_stop();

        // R11: ack held until next event, master slot outside transmit ignored
        do_start(); do_byte(8'hF8);
        repeat (4) @(negedge clk);
        chk(ack_en, "R11 ack held", ack_en, 1);
        do_mack(1'b0);
        chk(!ack_en && !tx_en, "R11 drop on mack", {ack_en, tx_en}, 0);
        do_stop();

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule